// File: doc/BRIEF.md
# Comma Detect Word Aligner

This block sits behind a clock and data recovery stage that hands over twenty raw, unaligned bits per parallel clock. Each clock therefore carries two ten-bit characters whose boundary inside the raw word is unknown. The block keeps a sliding history of the incoming bits and compares every possible starting position against the programmed comma characters. When it finds one, it moves its output boundary so that the comma starts a character in the output word.

The boundary is sticky. A comma found at the boundary already in use is reported but leaves the alignment as it is. A comma found at another bit offset moves the boundary and raises a realign pulse. This pulse is separate from the comma pulse. Detection can be switched off. The block then holds whatever boundary it has and passes data through at that boundary. There are four match modes: the first pattern alone, the second pattern alone, either pattern, or a twenty-bit sequence made of the first pattern followed at once by the second. For the usual 8B/10B comma pair, the second pattern is programmed as the bitwise inverse of the first.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, out_word, comma_det and realign are all zero. Until the first comma is detected, the boundary is offset 0, so each output word is the raw input stream taken unshifted.
- R2: Bit order is transmission order. in_data[0] is the earliest bit of a word and pattern bit 0 is compared against the earliest bit. If raw word k is presented in cycle k and the stream bits are numbered from 0, then the output registered at the end of cycle k is stream bits 20*(k-1)+off .. 20*(k-1)+off+19, with out_word[0] the earliest bit and out_word[9:0] the earlier character.
- R3: When a comma is found at a bit offset that differs from the current one, comma_det and realign are both high for exactly one cycle. In that same cycle, out_word already uses the new boundary and holds the comma at bit 0 or bit 10.
- R4: When a comma is found at the current offset, comma_det pulses, realign stays low and the boundary is unchanged.
- R5: The offset changes only in a cycle that reports realign. It always stays in the range 0 to 9.
- R6: match_mode selects the match: 0 matches pat_a, 1 matches pat_b, 2 matches either, and 3 matches pat_a immediately followed by pat_b (20 bits, with the boundary taken from the start of pat_a). A pattern not selected by the mode produces no pulse and moves nothing.
- R7: With det_en low, comma_det and realign stay low and the boundary is held, even when commas arrive at other offsets.
- R8: If several matches with different offsets fall into one search window, the one starting at the earliest bit decides the new offset.
- R9: realign is never high without comma_det.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 20 | Raw unaligned bits, bit 0 received first |
| det_en | input | 1 | Enables comma search and realignment |
| match_mode | input | 2 | 0 pat_a, 1 pat_b, 2 either, 3 pat_a then pat_b |
| pat_a | input | 10 | First (plus) match pattern, transmission order |
| pat_b | input | 10 | Second (minus) match pattern, transmission order |
| out_word | output | 20 | Aligned word, two characters |
| comma_det | output | 1 | One-cycle pulse: output word holds a comma |
| realign | output | 1 | One-cycle pulse: boundary moved to a new offset |

## Verification
The properties take for granted that match_mode, pat_a and pat_b are held steady while a stream is applied. They also assume the filler data between commas never forms a programmed pattern by accident, since any such chance match would be a legitimate realign. The stimulus meets both conditions. Every scenario starts from reset with fixed configuration. The filler is an alternating 0101 pattern, which can contain neither the five-ones run of the plus comma nor the five-zeros run of the minus comma. Commas are placed at chosen absolute bit positions so that the expected offset, the cycle of detection and the position inside the output word all follow from simple arithmetic.

// File: rtl/cwa_pkg.sv
`timescale 1ns/1ps
package cwa_pkg;

   typedef enum logic [1:0] {
      MATCH_A    = 2'd0,
      MATCH_B    = 2'd1,
      MATCH_EITHER = 2'd2,
      MATCH_SEQ  = 2'd3
   } match_mode_e;

endpackage

// File: rtl/cwa_history.sv
`timescale 1ns/1ps
module cwa_history #(
   parameter int WORD_W = 20,
   parameter int SW     = 39
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] in_data,
   output logic [SW-1:0]     stream
);
   localparam int NEW_W = SW - WORD_W;

   logic [WORD_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= in_data;
   end

   // older word in the low bits, so index order equals arrival order
   assign stream = {in_data[NEW_W-1:0], prev_q};

endmodule

// File: rtl/cwa_matcher.sv
`timescale 1ns/1ps
module cwa_matcher #(
   parameter int CHAR_W = 10,
   parameter int WORD_W = 20,
   parameter int SW     = 39,
   parameter int OFF_W  = 4
) (
   input  logic [SW-1:0]        stream,
   input  cwa_pkg::match_mode_e mode,
   input  logic [CHAR_W-1:0]    pat_a,
   input  logic [CHAR_W-1:0]    pat_b,
   output logic                 hit,
   output logic [OFF_W-1:0]     hit_off
);
   localparam int NPOS = WORD_W;

   logic [NPOS-1:0] hit_vec;

   for (genvar p = 0; p < NPOS; p++) begin : g_pos
      logic is_a, is_b, is_seq, sel;
      assign is_a   = (stream[p +: CHAR_W] == pat_a);
      assign is_b   = (stream[p +: CHAR_W] == pat_b);
      assign is_seq = is_a && (stream[p+CHAR_W +: CHAR_W] == pat_b);
      always_comb begin
         unique case (mode)
            cwa_pkg::MATCH_A:      sel = is_a;
            cwa_pkg::MATCH_B:      sel = is_b;
            cwa_pkg::MATCH_EITHER: sel = is_a | is_b;
            default:               sel = is_seq;
         endcase
      end
      assign hit_vec[p] = sel;
   end

   // earliest bit position wins
   always_comb begin
      hit     = |hit_vec;
      hit_off = '0;
      for (int i = NPOS-1; i >= 0; i--) begin
         if (hit_vec[i]) hit_off = OFF_W'(i % CHAR_W);
      end
   end

endmodule

// File: rtl/cwa_shifter.sv
`timescale 1ns/1ps
module cwa_shifter #(
   parameter int CHAR_W = 10,
   parameter int WORD_W = 20,
   parameter int OFF_W  = 4
) (
   input  logic [WORD_W+CHAR_W-2:0] stream,
   input  logic [OFF_W-1:0]         off,
   output logic [WORD_W-1:0]        word
);
   logic [WORD_W-1:0] cand [CHAR_W];

   for (genvar o = 0; o < CHAR_W; o++) begin : g_cand
      assign cand[o] = stream[o +: WORD_W];
   end

   always_comb begin
      word = cand[0];
      for (int o = 1; o < CHAR_W; o++) begin
         if (off == OFF_W'(o)) word = cand[o];
      end
   end

endmodule

// File: rtl/comma_word_aligner.sv
`timescale 1ns/1ps
module comma_word_aligner #(
   parameter int CHAR_W = 10,
   parameter int NCHAR  = 2,
   localparam int WORD_W = CHAR_W * NCHAR,
   localparam int OFF_W  = $clog2(CHAR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] in_data,
   input  logic              det_en,
   input  logic [1:0]        match_mode,
   input  logic [CHAR_W-1:0] pat_a,
   input  logic [CHAR_W-1:0] pat_b,
   output logic [WORD_W-1:0] out_word,
   output logic              comma_det,
   output logic              realign
);
   localparam int SW  = WORD_W + 2*CHAR_W - 1;
   localparam int SHW = WORD_W + CHAR_W - 1;

   if (CHAR_W < 2) begin : g_bad_char
      $error("comma_word_aligner: CHAR_W must be at least 2");
   end
   if (NCHAR < 2) begin : g_bad_nchar
      $error("comma_word_aligner: NCHAR must be at least 2");
   end

   logic [SW-1:0]     stream;
   logic              hit;
   logic [OFF_W-1:0]  hit_off;
   logic [OFF_W-1:0]  off_q;
   logic [OFF_W-1:0]  next_off;
   logic              take;
   logic [WORD_W-1:0] shifted;

   cwa_history #(.WORD_W(WORD_W), .SW(SW)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_data (in_data),
      .stream  (stream)
   );

   cwa_matcher #(.CHAR_W(CHAR_W), .WORD_W(WORD_W), .SW(SW), .OFF_W(OFF_W)) u_match (
      .stream  (stream),
      .mode    (cwa_pkg::match_mode_e'(match_mode)),
      .pat_a   (pat_a),
      .pat_b   (pat_b),
      .hit     (hit),
      .hit_off (hit_off)
   );

   assign take     = det_en && hit;
   assign next_off = take ? hit_off : off_q;

   cwa_shifter #(.CHAR_W(CHAR_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_shift (
      .stream (stream[SHW-1:0]),
      .off    (next_off),
      .word   (shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q     <= '0;
         out_word  <= '0;
         comma_det <= 1'b0;
         realign   <= 1'b0;
      end else begin
         off_q     <= next_off;
         out_word  <= shifted;
         comma_det <= take;
         realign   <= take && (hit_off != off_q);
      end
   end

endmodule

// File: rtl/cwa_checker.sv
`timescale 1ns/1ps
module cwa_checker #(
   parameter int CHAR_W = 10,
   parameter int OFF_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             det_en,
   input logic             comma_det,
   input logic             realign,
   input logic [OFF_W-1:0] off_q
);
   assert_realign_needs_det_R9: assert property (@(posedge clk) disable iff (!rst_n)
      realign |-> comma_det);

   assert_offset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !realign |-> $stable(off_q));

   assert_offset_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      realign |-> (off_q != $past(off_q)));

   assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= OFF_W'(CHAR_W-1));

   assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> (!comma_det && !realign));

endmodule

bind comma_word_aligner cwa_checker #(.CHAR_W(CHAR_W), .OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .det_en    (det_en),
   .comma_det (comma_det),
   .realign   (realign),
   .off_q     (off_q)
);

// File: tb/comma_word_aligner_tb.sv
`timescale 1ns/1ps
module comma_word_aligner_tb;
   localparam int NW = 14;
   localparam int NB = NW * 20;
   localparam logic [9:0] KP = 10'h17C;  // 0011111010, first bit at index 0
   localparam logic [9:0] KM = 10'h283;  // 1100000101

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [19:0] in_data = '0;
   logic det_en = 1'b0;
   logic [1:0] match_mode = 2'd0;
   logic [9:0] pat_a = KP;
   logic [9:0] pat_b = KM;
   logic [19:0] out_word;
   logic comma_det, realign;

   int tests = 0;
   int fails = 0;

   logic bits [NB];
   logic en_arr [NW];
   logic [19:0] rec_word [NW];
   logic rec_det [NW];
   logic rec_re [NW];

   always #2.5 clk = ~clk;

   comma_word_aligner u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .det_en(det_en),
      .match_mode(match_mode), .pat_a(pat_a), .pat_b(pat_b),
      .out_word(out_word), .comma_det(comma_det), .realign(realign)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [19:0] seg(input int s);
      logic [19:0] w;
      for (int j = 0; j < 20; j++) w[j] = bits[s+j];
      return w;
   endfunction

   function automatic int det_count();
      int c = 0;
      for (int k = 0; k < NW; k++) if (rec_det[k]) c++;
      return c;
   endfunction

   function automatic int re_count();
      int c = 0;
      for (int k = 0; k < NW; k++) if (rec_re[k]) c++;
      return c;
   endfunction

   task automatic prep(input logic [1:0] m, input logic en);
      for (int i = 0; i < NB; i++) bits[i] = i[0];
      for (int k = 0; k < NW; k++) en_arr[k] = en;
      match_mode = m;
   endtask

   task automatic place(input logic [9:0] p, input int a);
      for (int j = 0; j < 10; j++) bits[a+j] = p[j];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_data = '0;
      det_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_stream();
      do_reset();
      for (int k = 0; k < NW; k++) begin
         @(negedge clk);
         det_en = en_arr[k];
         for (int j = 0; j < 20; j++) in_data[j] = bits[20*k+j];
         @(posedge clk);
         #1;
         rec_word[k] = out_word;
         rec_det[k] = comma_det;
         rec_re[k] = realign;
      end
   endtask

   task automatic t_reset();
      prep(2'd0, 1'b1);
      do_reset();
      #1;
      chk("R1", "out_word after reset", 32'(out_word), 32'h0);
      chk("R1", "comma_det after reset", 32'(comma_det), 32'h0);
      chk("R1", "realign after reset", 32'(realign), 32'h0);
   endtask

   task automatic t_no_comma();
      prep(2'd0, 1'b1);
      run_stream();
      chk("R1", "no pulses without comma", 32'(det_count() + re_count()), 32'h0);
      chk("R2", "word 1 at offset 0", 32'(rec_word[1]), 32'(seg(0)));
      chk("R2", "word 6 at offset 0", 32'(rec_word[6]), 32'(seg(100)));
   endtask

   task automatic t_sticky();
      prep(2'd0, 1'b1);
      place(KP, 47);
      place(KP, 127);
      place(KP, 163);
      run_stream();
      chk("R3", "det on first comma", 32'(rec_det[3]), 32'h1);
      chk("R3", "realign on first comma", 32'(rec_re[3]), 32'h1);
      chk("R3", "comma at bit 0", 32'(rec_word[3][9:0]), 32'(KP));
      chk("R2", "word 5 at offset 7", 32'(rec_word[5]), 32'(seg(87)));
      chk("R4", "det on same offset", 32'(rec_det[7]), 32'h1);
      chk("R4", "no realign same offset", 32'(rec_re[7]), 32'h0);
      chk("R3", "realign to offset 3", 32'(rec_re[9]), 32'h1);
      chk("R5", "word 10 at offset 3", 32'(rec_word[10]), 32'(seg(183)));
      chk("R3", "pulse counts", 32'(det_count()*16 + re_count()), 32'h32);
   endtask

   task automatic t_minus();
      prep(2'd1, 1'b1);
      place(KP, 25);
      place(KM, 65);
      run_stream();
      chk("R6", "pat_a ignored in mode 1", 32'(rec_det[2]), 32'h0);
      chk("R6", "word 2 unshifted", 32'(rec_word[2]), 32'(seg(20)));
      chk("R6", "pat_b detected", 32'(rec_det[4] & rec_re[4]), 32'h1);
      chk("R6", "pat_b at bit 0", 32'(rec_word[4][9:0]), 32'(KM));
   endtask

   task automatic t_either();
      prep(2'd2, 1'b1);
      place(KP, 33);
      place(KM, 88);
      run_stream();
      chk("R6", "either: pat_a", 32'(rec_det[2] & rec_re[2]), 32'h1);
      chk("R6", "either: pat_a at bit 10", 32'(rec_word[2][19:10]), 32'(KP));
      chk("R6", "either: pat_b", 32'(rec_det[5] & rec_re[5]), 32'h1);
      chk("R6", "either: pat_b at bit 0", 32'(rec_word[5][9:0]), 32'(KM));
   endtask

   task automatic t_seq();
      prep(2'd3, 1'b1);
      place(KP, 45);
      place(KP, 104);
      place(KM, 114);
      run_stream();
      chk("R6", "lone pat_a ignored in mode 3", 32'(rec_det[3]), 32'h0);
      chk("R6", "sequence detected", 32'(rec_det[6] & rec_re[6]), 32'h1);
      chk("R6", "sequence aligned", 32'(rec_word[6]), 32'({KM, KP}));
      chk("R6", "single sequence pulse", 32'(det_count()), 32'h1);
   endtask

   task automatic t_disabled();
      prep(2'd0, 1'b0);
      place(KP, 47);
      run_stream();
      chk("R7", "no pulses when disabled", 32'(det_count() + re_count()), 32'h0);
      chk("R7", "word 3 unshifted", 32'(rec_word[3]), 32'(seg(40)));
      prep(2'd0, 1'b1);
      for (int k = 5; k < NW; k++) en_arr[k] = 1'b0;
      place(KP, 47);
      place(KP, 123);
      run_stream();
      chk("R7", "first comma while enabled", 32'(rec_re[3]), 32'h1);
      chk("R7", "later comma ignored", 32'(rec_det[7] | rec_re[7]), 32'h0);
      chk("R7", "offset 7 held", 32'(rec_word[8]), 32'(seg(147)));
   endtask

   task automatic t_priority();
      prep(2'd0, 1'b1);
      place(KP, 41);
      place(KP, 54);
      run_stream();
      chk("R8", "one pulse", 32'(rec_det[3] & rec_re[3]), 32'h1);
      chk("R8", "earliest wins", 32'(rec_word[3][9:0]), 32'(KP));
      chk("R8", "next word at offset 1", 32'(rec_word[4]), 32'(seg(61)));
      chk("R9", "realign count not above det count", 32'(re_count() <= det_count()), 32'h1);
   endtask

   initial begin
      #1_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_no_comma();
      t_sticky();
      t_minus();
      t_either();
      t_seq();
      t_disabled();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule